// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block controls a four-channel, 12-bit successive-approximation converter through a small memory-mapped register set. Software powers the converter up, runs an optional calibration pass, picks channels in a channel-enable mask and starts a one-shot scan. The sequencer visits each enabled channel in ascending order. For each channel it holds a sample phase and then a conversion phase. At the end of the conversion phase it stores the value presented on the digital sample input into that channel's result register. When the last channel is stored it raises an end-of-conversion flag. This flag is cleared by writing one to it, and it can drive an interrupt line.

The analog part lies outside the block. It appears as a 12-bit sample input, read while `ana_chan` names the channel being converted, and a calibration pass input, sampled when the fixed calibration time ends. A status register reports the operating state as a three-bit code, together with a calibration-busy bit and a calibration-failed bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000_0001 (power-down set), the status register reads 1, the interrupt status reads 0, every result register reads 0 and `irq` is low.
- R2: While control bit 0 (power-down) is 1, the state code in status bits [2:0] is 1 from the second cycle after the write. A scan in progress is abandoned with no end-of-conversion and no result written.
- R3: When bit 0 is cleared, the status code becomes 2 (wait) for WAKE_CYC cycles and then 0 (idle).
- R4: Writing control bit 14 (calibration start) while idle gives status code 3 with status bit 29 set for CAL_CYC cycles. The block then returns to idle, and status bit 30 holds the inverse of `ana_cal_ok` as sampled at the end.
- R5: Bit 24 (start) and bit 14 are acted on only when the block is idle, bit 0 is 0 in the old and the new control value, and bit 29 (mode) is 0 in the written value. A write in any other case is dropped and does not start anything. Both bits always read 0.
- R6: An accepted start snapshots the channel mask at 0xA4 (bits [3:0]). For each set bit, in ascending order, the status shows code 4 for SAMP_CYC cycles and then code 6 for CONV_CYC cycles. The block then stores `ana_sample` into bits [11:0] of the result register at 0x100 + 4×channel. Channels that are not enabled keep their value.
- R7: After the last enabled channel is stored, interrupt-status bit 1 (at 0x10) is set and the state returns to idle. A start with an empty mask sets bit 1 at once.
- R8: Writing 1 to interrupt-status bit 1 clears it. Writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R9: `irq` is high exactly when interrupt-status bit 1 and interrupt-mask bit 1 (at 0x20) are both set.
- R10: The following fields read back what was written: control bits 0, 8 and 29; the interrupt mask bits [1:0]; the channel interrupt mask at 0x24 bits [3:0]; and the channel mask bits [3:0]. Read data appears one cycle after `bus_re`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data follows one cycle later |
| bus_rdata | output | 32 | Registered read data |
| ana_sample | input | 12 | Digitised value of the channel on `ana_chan` |
| ana_cal_ok | input | 1 | Calibration pass indication from the converter |
| ana_chan | output | 2 | Channel currently being sampled or converted |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
Every result has a fixed due time, counted from the clock edge that captured the write which started it. The status code reads wait two cycles after power-up and reads idle from the fourth cycle. The end-of-conversion flag and each stored result are due at N×(SAMP_CYC+CONV_CYC) edges after a start that covers N channels. The calibration flags are due at CAL_CYC edges. The bench numbers clock edges from each triggering write and issues every read so that the edge capturing it lands on a chosen offset. Each expected value therefore matches the state after the edge one earlier. A scoreboard queue pairs each read with its expected word in issue order.

// File: rtl/adc_seq_pkg.sv
// Package: shared state codes, register offsets and bit positions for the
// ADC conversion sequencer. Assumes byte addressing with 32-bit registers.
package adc_seq_pkg;

    // Operating state codes, visible in status bits [2:0].
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PDN  = 3'd1,
        ST_WAIT = 3'd2,
        ST_CAL  = 3'd3,
        ST_SAMP = 3'd4,
        ST_CONV = 3'd6
    } seq_state_t;

    localparam int ADDR_W    = 12;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_ISR  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_IMR  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CIMR = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_NCMR = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_RES  = 12'h100;

    localparam int CTRL_PD     = 0;
    localparam int CTRL_CLKSEL = 8;
    localparam int CTRL_CALGO  = 14;
    localparam int CTRL_GO     = 24;
    localparam int CTRL_MODE   = 29;
    localparam int STAT_CALBSY = 29;
    localparam int STAT_CALBAD = 30;
    localparam int ISR_EOC     = 1;

endpackage

// File: rtl/adc_seq_fsm.sv
// Module: operating-state sequencer. Walks power-down, wake, calibration and
// the sample/convert scan over a snapshot of the channel mask.
// Assumes go pulses arrive only while idle; pd_req overrides every state.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMP_CYC = 3,
    parameter int CONV_CYC = 4,
    parameter int CAL_CYC  = 8,
    parameter int WAKE_CYC = 2,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_req,
    input  logic              conv_go,
    input  logic              cal_go,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic              cal_ok,
    output seq_state_t        state_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              res_we,
    output logic              eoc_set,
    output logic              cal_fail_o
);

    localparam int MAX_AB = (SAMP_CYC > CONV_CYC) ? SAMP_CYC : CONV_CYC;
    localparam int MAX_CD = (CAL_CYC > WAKE_CYC) ? CAL_CYC : WAKE_CYC;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [NUM_CH-1:0] pend_q, pend_d, rest;
    logic [CH_W-1:0]   chan_q, chan_d;
    logic              fail_q, fail_d;

    // Index of the lowest set bit in a channel mask.
    function automatic logic [CH_W-1:0] lowest(input logic [NUM_CH-1:0] m);
        logic [CH_W-1:0] idx;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i]) idx = CH_W'(i);
        end
        return idx;
    endfunction

    // Next-state, counter and scan bookkeeping.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        chan_d  = chan_q;
        fail_d  = fail_q;
        res_we  = 1'b0;
        eoc_set = 1'b0;
        rest    = pend_q;
        rest[chan_q] = 1'b0;
        if (pd_req) begin
            state_d = ST_PDN;
            pend_d  = '0;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_PDN: begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                end
                ST_WAIT: begin
                    if (cnt_q == CNT_W'(WAKE_CYC - 1)) state_d = ST_IDLE;
                    else cnt_d = cnt_q + 1'b1;
                end
                ST_IDLE: begin
                    cnt_d = '0;
                    if (cal_go) begin
                        state_d = ST_CAL;
                    end else if (conv_go) begin
                        if (chan_mask == '0) begin
                            eoc_set = 1'b1;
                        end else begin
                            pend_d  = chan_mask;
                            chan_d  = lowest(chan_mask);
                            state_d = ST_SAMP;
                        end
                    end
                end
                ST_CAL: begin
                    if (cnt_q == CNT_W'(CAL_CYC - 1)) begin
                        state_d = ST_IDLE;
                        fail_d  = !cal_ok;
                        cnt_d   = '0;
                    end else cnt_d = cnt_q + 1'b1;
                end
                ST_SAMP: begin
                    if (cnt_q == CNT_W'(SAMP_CYC - 1)) begin
                        state_d = ST_CONV;
                        cnt_d   = '0;
                    end else cnt_d = cnt_q + 1'b1;
                end
                ST_CONV: begin
                    if (cnt_q == CNT_W'(CONV_CYC - 1)) begin
                        res_we = 1'b1;
                        pend_d = rest;
                        cnt_d  = '0;
                        if (rest == '0) begin
                            state_d = ST_IDLE;
                            eoc_set = 1'b1;
                        end else begin
                            chan_d  = lowest(rest);
                            state_d = ST_SAMP;
                        end
                    end else cnt_d = cnt_q + 1'b1;
                end
                default: state_d = ST_PDN;
            endcase
        end
    end

    // State registers; reset lands in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PDN;
            cnt_q   <= '0;
            pend_q  <= '0;
            chan_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
            chan_q  <= chan_d;
            fail_q  <= fail_d;
        end
    end

    assign state_o    = state_q;
    assign chan_o     = chan_q;
    assign cal_fail_o = fail_q;

    p_pd_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> state_q == ST_PDN);
    p_wait_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> ($past(state_q) == ST_PDN || $past(state_q) == ST_WAIT));
    p_cal_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cal_go && !pd_req) |=> state_q == ST_CAL);
    p_conv_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |-> ($past(state_q) == ST_SAMP || $past(state_q) == ST_CONV));
    p_eoc_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_set |-> (state_q == ST_CONV || state_q == ST_IDLE));

endmodule

// File: rtl/adc_seq_results.sv
// Module: per-channel result storage. One register per channel, loaded from
// the sample input when the sequencer strobes the write for that channel.
// Assumes ch is below NUM_CH whenever we is high.
module adc_seq_results #(
    parameter int NUM_CH  = 4,
    parameter int DATA_W  = 12,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [CH_W-1:0]                ch,
    input  logic [DATA_W-1:0]              din,
    output logic [NUM_CH-1:0][DATA_W-1:0]  res_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        // Capture the converted value for channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)                         res_o[g] <= '0;
            else if (we && ch == CH_W'(g))      res_o[g] <= din;
        end
    end

    p_res_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(res_o));

endmodule

// File: rtl/adc_seq_regs.sv
// Module: register file and bus decode. Holds control fields, interrupt
// status and masks, and the channel mask, and forms the start pulses.
// Assumes single-cycle write strobes and one read per bus_re cycle.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    input  logic                          bus_we,
    input  logic                          bus_re,
    output logic [31:0]                   bus_rdata,
    input  seq_state_t                    state_i,
    input  logic                          cal_fail_i,
    input  logic                          eoc_set_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0] results_i,
    output logic                          pd_q_o,
    output logic                          conv_go_o,
    output logic                          cal_go_o,
    output logic [NUM_CH-1:0]             chan_mask_o,
    output logic                          irq_o
);

    logic              pd_q, clksel_q, mode_q, eoc_q;
    logic [1:0]        imr_q;
    logic [NUM_CH-1:0] cimr_q, ncmr_q;
    logic [31:0]       rd_val, rdata_q;
    logic              wr_ctrl, go_ok, eoc_clr;

    assign wr_ctrl = bus_we && bus_addr == OFS_CTRL;
    assign go_ok   = wr_ctrl && state_i == ST_IDLE && !pd_q
                     && !bus_wdata[CTRL_PD] && !bus_wdata[CTRL_MODE];
    assign cal_go_o  = go_ok && bus_wdata[CTRL_CALGO];
    assign conv_go_o = go_ok && bus_wdata[CTRL_GO] && !bus_wdata[CTRL_CALGO];
    assign eoc_clr   = bus_we && bus_addr == OFS_ISR && bus_wdata[ISR_EOC];

    // Control fields and mask registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q     <= 1'b1;
            clksel_q <= 1'b0;
            mode_q   <= 1'b0;
            imr_q    <= '0;
            cimr_q   <= '0;
            ncmr_q   <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_CTRL) begin
                pd_q     <= bus_wdata[CTRL_PD];
                clksel_q <= bus_wdata[CTRL_CLKSEL];
                mode_q   <= bus_wdata[CTRL_MODE];
            end
            if (bus_addr == OFS_IMR)  imr_q  <= bus_wdata[1:0];
            if (bus_addr == OFS_CIMR) cimr_q <= bus_wdata[NUM_CH-1:0];
            if (bus_addr == OFS_NCMR) ncmr_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    // End-of-conversion flag: set by the sequencer, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)         eoc_q <= 1'b0;
        else if (eoc_set_i) eoc_q <= 1'b1;
        else if (eoc_clr)   eoc_q <= 1'b0;
    end

    // Read multiplexer over all mapped registers.
    always_comb begin
        rd_val = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                rd_val[CTRL_PD]     = pd_q;
                rd_val[CTRL_CLKSEL] = clksel_q;
                rd_val[CTRL_MODE]   = mode_q;
            end
            OFS_STAT: begin
                rd_val[2:0]         = state_i;
                rd_val[STAT_CALBSY] = (state_i == ST_CAL);
                rd_val[STAT_CALBAD] = cal_fail_i;
            end
            OFS_ISR:  rd_val[ISR_EOC]     = eoc_q;
            OFS_IMR:  rd_val[1:0]         = imr_q;
            OFS_CIMR: rd_val[NUM_CH-1:0]  = cimr_q;
            OFS_NCMR: rd_val[NUM_CH-1:0]  = ncmr_q;
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (bus_addr == ADDR_W'(OFS_RES + 4 * i))
                        rd_val[DATA_W-1:0] = results_i[i];
                end
            end
        endcase
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign bus_rdata   = rdata_q;
    assign pd_q_o      = pd_q;
    assign chan_mask_o = ncmr_q;
    assign irq_o       = eoc_q && imr_q[ISR_EOC];

    p_eoc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_set_i |=> eoc_q);
    p_eoc_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_clr && !eoc_set_i) |=> !eoc_q);
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(eoc_set_i || (bus_we && bus_addr == OFS_IMR)));
    p_go_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_IDLE) |-> !(conv_go_o || cal_go_o));

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top of the ADC conversion sequencer. Ties the register file, the
// state sequencer and the result storage together.
// Assumes the converter model presents ana_sample for the channel on ana_chan.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DATA_W   = 12,
    parameter int SAMP_CYC = 3,
    parameter int CONV_CYC = 4,
    parameter int CAL_CYC  = 8,
    parameter int WAKE_CYC = 2,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [DATA_W-1:0] ana_sample,
    input  logic              ana_cal_ok,
    output logic [CH_W-1:0]   ana_chan,
    output logic              irq
);

    seq_state_t                    state;
    logic                          pd_q, conv_go, cal_go, res_we, eoc_set, cal_fail;
    logic [NUM_CH-1:0]             chan_mask;
    logic [NUM_CH-1:0][DATA_W-1:0] results;

    adc_seq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata),
        .state_i(state), .cal_fail_i(cal_fail), .eoc_set_i(eoc_set),
        .results_i(results), .pd_q_o(pd_q), .conv_go_o(conv_go),
        .cal_go_o(cal_go), .chan_mask_o(chan_mask), .irq_o(irq)
    );

    adc_seq_fsm #(.NUM_CH(NUM_CH), .SAMP_CYC(SAMP_CYC), .CONV_CYC(CONV_CYC),
                  .CAL_CYC(CAL_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_q), .conv_go(conv_go),
        .cal_go(cal_go), .chan_mask(chan_mask), .cal_ok(ana_cal_ok),
        .state_o(state), .chan_o(ana_chan), .res_we(res_we),
        .eoc_set(eoc_set), .cal_fail_o(cal_fail)
    );

    adc_seq_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .we(res_we), .ch(ana_chan),
        .din(ana_sample), .res_o(results)
    );

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [11:0] ana_sample;
    logic        ana_cal_ok = 1'b1;
    logic [1:0]  ana_chan;
    logic        irq;
    logic [11:0] seed = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model: value depends on the channel being converted.
    assign ana_sample = 12'hA00 + 12'(ana_chan) * 12'h011 + seed;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .ana_sample(ana_sample), .ana_cal_ok(ana_cal_ok),
        .ana_chan(ana_chan), .irq(irq)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, t0 = 0;
    bit done = 0, re_q = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        re_q <= bus_re;
    end

    // Monitor: pops the expected word for every completed read.
    always @(negedge clk) begin
        if (re_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: read 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        t0 = cyc + 1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // Wait so the next operation is captured at edge t0 + k.
    task automatic at(input int k);
        while (cyc + 1 < t0 + k) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq %0b expected %0b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(12'h000, 32'h1, "R1 ctrl");
        rd(12'h004, 32'h1, "R1 status");
        rd(12'h010, 32'h0, "R1 isr");
        rd(12'h10C, 32'h0, "R1 result3");
        chk_irq(1'b0, "R1 irq");
        rd(12'h040, 32'h0, "R10 unmapped");
        // R3 wake-up through wait
        wr(12'h000, 32'h100);
        at(2); rd(12'h004, 32'h2, "R3 wait");
        at(4); rd(12'h004, 32'h0, "R3 idle");
        // R10 readback
        wr(12'h020, 32'h3);  rd(12'h020, 32'h3, "R10 imr");
        wr(12'h024, 32'hF);  rd(12'h024, 32'hF, "R10 cimr");
        wr(12'h0A4, 32'h5);  rd(12'h0A4, 32'h5, "R10 ncmr");
        rd(12'h000, 32'h100, "R10 ctrl");
        rd(12'h108, 32'h0, "R1 result2");
        // R4 calibration fail, with a start dropped during it (R5)
        ana_cal_ok = 1'b0;
        wr(12'h000, 32'h4100);
        at(1); rd(12'h004, 32'h2000_0003, "R4 cal busy");
        at(3); begin int s; s = t0; wr(12'h000, 32'h0100_0100); t0 = s; end
        at(4); rd(12'h000, 32'h100, "R5 self-clear");
        at(8); rd(12'h004, 32'h2000_0003, "R4 cal last");
        at(9); rd(12'h004, 32'h4000_0000, "R4 cal fail");
        at(11); rd(12'h004, 32'h4000_0000, "R5 no start");
        // R4 calibration pass
        ana_cal_ok = 1'b1;
        wr(12'h000, 32'h4100);
        at(10); rd(12'h004, 32'h0, "R4 cal pass");
        // R5 mode 1 drops start
        wr(12'h000, 32'h2100_0100);
        at(1); rd(12'h004, 32'h0, "R5 mode1");
        rd(12'h000, 32'h2000_0100, "R10 mode bit");
        wr(12'h000, 32'h100);
        // R6/R7 scan channels 0 and 2
        seed = 12'h001;
        wr(12'h000, 32'h0100_0100);
        at(1);  rd(12'h004, 32'h4, "R6 sample ch0");
        at(5);  rd(12'h004, 32'h6, "R6 convert ch0");
        at(8);  rd(12'h004, 32'h4, "R6 sample ch2");
        at(14); rd(12'h004, 32'h6, "R6 convert ch2");
        at(15); rd(12'h010, 32'h2, "R7 eoc");
        chk_irq(1'b1, "R9 irq set");
        rd(12'h100, 32'hA01, "R6 result0");
        rd(12'h104, 32'h0,   "R6 result1 untouched");
        rd(12'h108, 32'hA23, "R6 result2");
        // R8 write-one-to-clear
        wr(12'h010, 32'h0); rd(12'h010, 32'h2, "R8 write0 keeps");
        chk_irq(1'b1, "R9 irq held");
        wr(12'h010, 32'h2); rd(12'h010, 32'h0, "R8 write1 clears");
        chk_irq(1'b0, "R9 irq cleared");
        // R9 masked, all four channels
        wr(12'h020, 32'h0); wr(12'h0A4, 32'hF);
        seed = 12'h005;
        wr(12'h000, 32'h0100_0100);
        at(28); rd(12'h010, 32'h0, "R7 not yet");
        at(29); rd(12'h010, 32'h2, "R7 eoc four");
        chk_irq(1'b0, "R9 masked");
        rd(12'h100, 32'hA05, "R6 r0");
        rd(12'h104, 32'hA16, "R6 r1");
        rd(12'h108, 32'hA27, "R6 r2");
        rd(12'h10C, 32'hA38, "R6 r3");
        wr(12'h020, 32'h2);
        chk_irq(1'b1, "R9 unmask");
        wr(12'h010, 32'h2);
        // R7 empty mask
        wr(12'h0A4, 32'h0);
        wr(12'h000, 32'h0100_0100);
        at(1); rd(12'h010, 32'h2, "R7 empty mask");
        rd(12'h004, 32'h0, "R7 idle");
        wr(12'h010, 32'h2);
        // R2 abort by power-down
        wr(12'h0A4, 32'h1);
        seed = 12'h009;
        wr(12'h000, 32'h0100_0100);
        at(3); begin int s; s = t0; wr(12'h000, 32'h1); t0 = s; end
        at(5);  rd(12'h004, 32'h1, "R2 power-down");
        at(12); rd(12'h010, 32'h0, "R2 no eoc");
        rd(12'h100, 32'hA05, "R2 result kept");
        // R5 start ignored while powered down
        wr(12'h000, 32'h0100_0001);
        at(2); rd(12'h004, 32'h1, "R5 pd start");
        rd(12'h010, 32'h0, "R5 pd no eoc");
        // R5 start dropped during wait
        wr(12'h000, 32'h100);
        at(2); begin int s; s = t0; wr(12'h000, 32'h0100_0100); t0 = s; end
        at(6); rd(12'h004, 32'h0, "R5 wait start");
        rd(12'h010, 32'h0, "R5 wait no eoc");
        done = 1;
        finish_run();
    end

endmodule